// File: doc/BRIEF.md
# BCD Calendar Clock with Full-Match Alarm

This block keeps wall-clock time as six BCD byte fields: seconds, minutes, hours, day of month, month and a two-digit year that stands for 2000 to 2099. A free-running 32.768 kHz tick, delivered as a one-cycle pulse in the system clock domain, feeds a prescaler. The prescaler steps the calendar once per second while the run bit is set. Hours always count in 24-hour form. Day-of-month rollover follows the month lengths, and February is given a 29th day when the year is a multiple of four.

Software reaches every field through a plain byte register bus that uses a select, a write strobe, an address and write data. Read data is combinational. The alarm compare is made once per second and requires all six alarm bytes to equal the newly stepped time. There is no per-field mask. The status register has sticky rollover and alarm flags that are cleared by writing 1. It also has a BUSY bit that is high during the final tick period before each step, so software can place its accesses just after BUSY falls. Two interrupt outputs combine the one-second flag and the alarm flag with their enable bits. The register bus carries no streaming data, so it has no valid/ready handshake and never applies back-pressure: every access completes in the cycle it is presented.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: After reset, seconds, minutes, hours and year read 0x00, day and month read 0x01, control, status and interrupt enable read 0x00, and both interrupt outputs are low.
- R2: Time fields are at byte addresses 0x00 seconds, 0x04 minutes, 0x08 hours, 0x0C day, 0x10 month and 0x14 year. A write loads the BCD byte at once and it reads back unchanged.
- R3: On each step, seconds and minutes wrap from 0x59 to 0x00 and hours wrap from 0x23 to 0x00, each wrap carrying into the next field. Status bit 3 is set when the minute advances and status bit 4 is set when the hour advances.
- R4: Day wraps to 0x01 after the last day of the month. Months 04, 06, 09 and 11 end at 30, February ends at 29 when the BCD year is divisible by 4 (00 counts) and at 28 otherwise, and all other months end at 31. Month 0x12 wraps to 0x01 and increments the year, and year 0x99 wraps to 0x00. Status bit 5 is set when the day advances.
- R5: Control register 0x40 bit 0 is the run bit. While it is 0, time holds, status bit 1 (RUN) reads 0 and status bit 0 (BUSY) reads 0.
- R6: The calendar steps once every TICKS_PER_SEC ticks. A write to any time field clears the prescaler, so the next step comes only after a full TICKS_PER_SEC further ticks, and BUSY reads 0 right after that write.
- R7: Status bit 0 (BUSY) is high for exactly one tick period, the one that ends with the step. The step happens at the tick where BUSY falls.
- R8: Alarm bytes are at 0x20, 0x24, 0x28, 0x2C, 0x30 and 0x34, in the same field order as the time bytes. Status bit 6 is set one cycle after a step when all six alarm bytes equal the new time. A difference in any single field keeps it clear.
- R9: Status bits 2 (one-second step), 3, 4, 5 and 6 are sticky. Writing 1 to a bit at address 0x44 clears it, writing 0 leaves it unchanged, and a new event in the same cycle wins over the clear.
- R10: irq_tick equals status bit 2 ANDed with interrupt-enable bit 2 at address 0x48. irq_alarm equals status bit 6 ANDed with interrupt-enable bit 3.
- R11: Only control bit 0 is stored. Writing control bit 3 (the 12-hour selector) has no effect: it reads back 0 and hours still wrap from 0x23 to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle pulse per 32.768 kHz period |
| reg_sel | input | 1 | Register access select |
| reg_we | input | 1 | Write strobe, qualified by reg_sel |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| irq_tick | output | 1 | One-second interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
The bench steps through the end of a leap February, a non-leap February, year 2000, a 30-day month and the end of the century. A wrong month-length or leap decode would produce a 29th or 31st day, or would skip one. It sets up a second with BUSY high and then writes a time field. A prescaler that is not cleared by that write would step within one tick instead of after a full second. It measures the BUSY width against the tick spacing and checks that an alarm differing only in the year stays silent. A comparator that ignored a field would fire there. It also confirms that writing 0 to status, or writing the 12-hour bit, changes nothing.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int unsigned NFIELDS = 6;

  localparam logic [7:0] ADDR_CTRL = 8'h40;
  localparam logic [7:0] ADDR_STAT = 8'h44;
  localparam logic [7:0] ADDR_IEN  = 8'h48;
  localparam logic [7:0] TIME_END  = 8'h18;
  localparam logic [7:0] ALM_BASE  = 8'h20;
  localparam logic [7:0] ALM_END   = 8'h38;

  typedef logic [7:0] bcd8_t;
  typedef logic [NFIELDS-1:0][7:0] cal_t;

  // next BCD value, no wrap handling
  function automatic bcd8_t bcd_next(bcd8_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // BCD year divisible by four
  function automatic logic leap_year(bcd8_t y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic bcd8_t month_last(bcd8_t m, bcd8_t y);
    case (m)
      8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic clr,
  output logic strobe,
  output logic busy
);
  localparam int unsigned CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last = (cnt == LAST);
  assign busy    = run & at_last;
  assign strobe  = run & tick & ~clr & at_last;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (run & tick) cnt <= at_last ? '0 : cnt + CW'(1);
  end

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt} < (CW+1)'(TICKS_PER_SEC));

  // R7
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!run || $past(clr) || $past(tick)));

endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       wr_en,
  input  logic [2:0] wr_field,
  input  logic [7:0] wr_data,
  output cal_t       now_o,
  output logic [3:1] roll_o
);
  cal_t               fld, fmax, fmin;
  logic [NFIELDS-1:0] inc;

  always_comb begin
    fmax[0] = 8'h59;
    fmax[1] = 8'h59;
    fmax[2] = 8'h23;
    fmax[3] = month_last(fld[4], fld[5]);
    fmax[4] = 8'h12;
    fmax[5] = 8'h99;
    fmin    = '0;
    fmin[3] = 8'h01;
    fmin[4] = 8'h01;
  end

  assign inc[0] = step;

  for (genvar f = 0; f < NFIELDS; f++) begin : g_field
    localparam logic [7:0] RSTV = (f == 3 || f == 4) ? 8'h01 : 8'h00;
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                        q <= RSTV;
      else if (wr_en && wr_field == 3'(f)) q <= wr_data;
      else if (inc[f])                   q <= (q == fmax[f]) ? fmin[f] : bcd_next(q);
    end
    assign fld[f] = q;
    if (f < NFIELDS - 1) begin : g_carry
      assign inc[f+1] = inc[f] & (q == fmax[f]);
    end
  end

  assign now_o  = fld;
  assign roll_o = inc[3:1];

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en && fld[0] == 8'h59) |=> (fld[0] == 8'h00));

  // R4
  day_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en && fld[0] == 8'h59 && fld[1] == 8'h59 && fld[2] == 8'h23
     && fld[3] == month_last(fld[4], fld[5])) |=> (fld[3] == 8'h01));

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_field,
  input  logic [7:0] wr_data,
  input  cal_t       now_i,
  output cal_t       alm_o,
  output logic       hit_o
);
  cal_t alm;

  for (genvar f = 0; f < NFIELDS; f++) begin : g_alm
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                          q <= 8'h00;
      else if (wr_en && wr_field == 3'(f)) q <= wr_data;
    end
    assign alm[f] = q;
  end

  assign alm_o = alm;
  assign hit_o = (alm == now_i);

endmodule

// File: rtl/bcd_calendar_rtc.sv
module bcd_calendar_rtc
  import rtc_cal_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic       reg_sel,
  input  logic       reg_we,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq_tick,
  output logic       irq_alarm
);
  logic       time_hit, alm_hit, wr;
  logic       time_wr, alm_wr;
  logic [2:0] fidx;
  logic       run_q, ien_tick_q, ien_alm_q, upd_q;
  logic       strobe, busy, match;
  logic [6:2] flags;
  logic [6:2] set_v;
  logic [3:1] roll;
  cal_t       now_t, alm_t;

  assign wr       = reg_sel & reg_we;
  assign fidx     = reg_addr[4:2];
  assign time_hit = (reg_addr < TIME_END) && (reg_addr[1:0] == 2'b00);
  assign alm_hit  = (reg_addr >= ALM_BASE) && (reg_addr < ALM_END) && (reg_addr[1:0] == 2'b00);
  assign time_wr  = wr & time_hit;
  assign alm_wr   = wr & alm_hit;

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_q),
    .tick   (tick_32k),
    .clr    (time_wr),
    .strobe (strobe),
    .busy   (busy)
  );

  rtc_time_counter u_time (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (strobe),
    .wr_en    (time_wr),
    .wr_field (fidx),
    .wr_data  (reg_wdata),
    .now_o    (now_t),
    .roll_o   (roll)
  );

  rtc_alarm_match u_alarm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (alm_wr),
    .wr_field (fidx),
    .wr_data  (reg_wdata),
    .now_i    (now_t),
    .alm_o    (alm_t),
    .hit_o    (match)
  );

  assign set_v = {upd_q & match, roll, strobe};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      ien_tick_q <= 1'b0;
      ien_alm_q  <= 1'b0;
      upd_q      <= 1'b0;
      flags      <= '0;
    end else begin
      upd_q <= strobe;
      if (wr && reg_addr == ADDR_CTRL) run_q <= reg_wdata[0];
      if (wr && reg_addr == ADDR_IEN) begin
        ien_tick_q <= reg_wdata[2];
        ien_alm_q  <= reg_wdata[3];
      end
      if (wr && reg_addr == ADDR_STAT) flags <= (flags & ~reg_wdata[6:2]) | set_v;
      else                             flags <= flags | set_v;
    end
  end

  assign irq_tick  = flags[2] & ien_tick_q;
  assign irq_alarm = flags[6] & ien_alm_q;

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_sel) begin
      if (time_hit || alm_hit) begin
        case (fidx)
          3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5:
            reg_rdata = time_hit ? now_t[fidx] : alm_t[fidx];
          default: reg_rdata = 8'h00;
        endcase
      end else if (reg_addr == ADDR_CTRL) begin
        reg_rdata = {7'b0, run_q};
      end else if (reg_addr == ADDR_STAT) begin
        reg_rdata = {1'b0, flags, run_q, busy};
      end else if (reg_addr == ADDR_IEN) begin
        reg_rdata = {4'b0, ien_alm_q, ien_tick_q, 2'b00};
      end
    end
  end

  // R8
  alarm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[6]) |-> $past(upd_q && match));

  // R5
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !time_wr) |=> $stable(now_t));

endmodule

// File: tb/bcd_calendar_rtc_tb.sv
module bcd_calendar_rtc_tb;
  localparam int TPS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32k = 1'b0;
  logic       reg_sel = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_tick, irq_alarm;
  int         checks = 0;
  int         errors = 0;
  int         ph = 0;

  bcd_calendar_rtc #(.TICKS_PER_SEC(TPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .reg_sel(reg_sel),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_tick(irq_tick), .irq_alarm(irq_alarm));

  always #10 clk = ~clk;

  initial forever begin
    @(negedge clk);
    ph = (ph == 2) ? 0 : ph + 1;
    tick_32k = (ph == 0);
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic set_time(logic [7:0] y, mo, dy, h, mi, s);
    wr(8'h14, y); wr(8'h10, mo); wr(8'h0C, dy);
    wr(8'h08, h); wr(8'h04, mi); wr(8'h00, s);
  endtask

  task automatic set_alarm(logic [7:0] y, mo, dy, h, mi, s);
    wr(8'h34, y); wr(8'h30, mo); wr(8'h2C, dy);
    wr(8'h28, h); wr(8'h24, mi); wr(8'h20, s);
  endtask

  task automatic chk_time(string req, logic [7:0] y, mo, dy, h, mi, s);
    logic [7:0] v;
    rd(8'h00, v); chk(req, v, s);
    rd(8'h04, v); chk(req, v, mi);
    rd(8'h08, v); chk(req, v, h);
    rd(8'h0C, v); chk(req, v, dy);
    rd(8'h10, v); chk(req, v, mo);
    rd(8'h14, v); chk(req, v, y);
  endtask

  // wait for the next one-second step (status bit 2), then settle
  task automatic next_second();
    logic [7:0] v;
    bit seen = 0;
    wr(8'h44, 8'h04);
    for (int i = 0; i < 100 && !seen; i++) begin
      rd(8'h44, v);
      if (v[2]) seen = 1;
      else @(negedge clk);
    end
    if (!seen) begin
      errors++;
      $display("FAIL R6 no step seen actual=0 expected=1");
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk_time("R1 reset time", 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    rd(8'h40, v); chk("R1 ctrl", v, 8'h00);
    rd(8'h44, v); chk("R1 status", v, 8'h00);
    rd(8'h48, v); chk("R1 ien", v, 8'h00);
    chk("R1 irqs", {6'b0, irq_tick, irq_alarm}, 8'h00);
  endtask

  task automatic t_stopped();
    logic [7:0] v;
    set_time(8'h42, 8'h07, 8'h19, 8'h08, 8'h30, 8'h15);
    chk_time("R2 load readback", 8'h42, 8'h07, 8'h19, 8'h08, 8'h30, 8'h15);
    repeat (40) @(negedge clk);
    chk_time("R5 hold while stopped", 8'h42, 8'h07, 8'h19, 8'h08, 8'h30, 8'h15);
    rd(8'h44, v); chk("R5 run/busy low", v & 8'h03, 8'h00);
  endtask

  task automatic t_ctrl();
    logic [7:0] v;
    wr(8'h40, 8'h09);
    rd(8'h40, v); chk("R11 ctrl readback", v, 8'h01);
    rd(8'h44, v); chk("R5 run status", v & 8'h02, 8'h02);
  endtask

  task automatic t_roll_hour();
    logic [7:0] v;
    set_time(8'h24, 8'h06, 8'h15, 8'h09, 8'h59, 8'h59);
    wr(8'h44, 8'h7C);
    next_second();
    chk_time("R3 hour carry", 8'h24, 8'h06, 8'h15, 8'h10, 8'h00, 8'h00);
    rd(8'h44, v); chk("R3 min/hr flags", v, 8'h1E);
    chk("R10 irq gated off", {6'b0, irq_tick, irq_alarm}, 8'h00);
  endtask

  task automatic t_day(string req, logic [7:0] y, mo, dy, ny, nmo, ndy);
    logic [7:0] v;
    set_time(y, mo, dy, 8'h23, 8'h59, 8'h59);
    wr(8'h44, 8'h7C);
    next_second();
    chk_time(req, ny, nmo, ndy, 8'h00, 8'h00, 8'h00);
    rd(8'h44, v); chk({req, " flags"}, v, 8'h3E);
  endtask

  task automatic t_prescale_clear();
    logic [7:0] v;
    bit seen = 0;
    set_time(8'h10, 8'h03, 8'h03, 8'h03, 8'h03, 8'h03);
    for (int i = 0; i < 100 && !seen; i++) begin
      rd(8'h44, v);
      if (v[0]) seen = 1;
      else @(negedge clk);
    end
    chk("R7 busy seen", {7'b0, seen}, 8'h01);
    wr(8'h00, 8'h10);
    rd(8'h44, v); chk("R6 busy clear after write", v & 8'h01, 8'h00);
    repeat (7) @(negedge clk);
    rd(8'h00, v); chk("R6 no early step", v, 8'h10);
    repeat (6) @(negedge clk);
    rd(8'h00, v); chk("R6 full second step", v, 8'h11);
  endtask

  task automatic t_busy();
    logic [7:0] v, s0, s1;
    int n = 0;
    bit seen = 0;
    set_time(8'h10, 8'h03, 8'h03, 8'h03, 8'h03, 8'h20);
    for (int i = 0; i < 100 && !seen; i++) begin
      rd(8'h44, v);
      if (v[0]) seen = 1;
      else @(negedge clk);
    end
    rd(8'h00, s0);
    for (int i = 0; i < 20 && v[0]; i++) begin
      n++;
      @(negedge clk);
      rd(8'h44, v);
    end
    rd(8'h00, s1);
    chk("R7 busy width", 8'(n), 8'd3);
    chk("R7 held during busy", s0, 8'h20);
    chk("R7 step at busy fall", s1, 8'h21);
  endtask

  task automatic t_alarm();
    logic [7:0] v;
    wr(8'h48, 8'h0C);
    set_alarm(8'h31, 8'h05, 8'h17, 8'h12, 8'h00, 8'h06);
    set_time(8'h31, 8'h05, 8'h17, 8'h12, 8'h00, 8'h05);
    wr(8'h44, 8'h7C);
    next_second();
    rd(8'h44, v); chk("R8 alarm flag", v & 8'h40, 8'h40);
    chk("R10 both irqs", {6'b0, irq_tick, irq_alarm}, 8'h03);
    wr(8'h44, 8'h00);
    rd(8'h44, v); chk("R9 write zero keeps", v & 8'h44, 8'h44);
    wr(8'h44, 8'h40);
    rd(8'h44, v); chk("R9 w1c alarm only", v & 8'h44, 8'h04);
    chk("R10 irq after clear", {6'b0, irq_tick, irq_alarm}, 8'h02);
    wr(8'h34, 8'h32);
    rd(8'h34, v); chk("R8 alarm readback", v, 8'h32);
    set_time(8'h31, 8'h05, 8'h17, 8'h12, 8'h00, 8'h05);
    wr(8'h44, 8'h7C);
    next_second();
    rd(8'h44, v); chk("R8 year mismatch silent", v & 8'h40, 8'h00);
    chk("R10 alarm irq low", {7'b0, irq_alarm}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stopped();
    t_ctrl();
    t_roll_hour();
    t_day("R4 leap feb 28", 8'h24, 8'h02, 8'h28, 8'h24, 8'h02, 8'h29);
    t_day("R4 leap feb 29", 8'h24, 8'h02, 8'h29, 8'h24, 8'h03, 8'h01);
    t_day("R4 nonleap feb", 8'h23, 8'h02, 8'h28, 8'h23, 8'h03, 8'h01);
    t_day("R4 year 00 leap", 8'h00, 8'h02, 8'h28, 8'h00, 8'h02, 8'h29);
    t_day("R4 30-day month", 8'h15, 8'h04, 8'h30, 8'h15, 8'h05, 8'h01);
    t_day("R4 31-day month", 8'h15, 8'h01, 8'h30, 8'h15, 8'h01, 8'h31);
    t_day("R4 century wrap R11", 8'h99, 8'h12, 8'h31, 8'h00, 8'h01, 8'h01);
    t_prescale_clear();
    t_busy();
    t_alarm();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule